// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a small shared-memory multiprocessor and keeps, for each of a handful of memory blocks, a directory entry made of a sharer vector (one bit per node) and an ownership flag. Nodes send read or write requests to it one at a time over a valid/ready handshake. The controller looks up the entry, talks only to the nodes that the entry names, and grants the request once the other copies are settled.

The controller keeps a clean block's sharers in the vector. A write to a clean block sends one invalidate message to each recorded sharer other than the requester, one per cycle. It counts the returned acknowledgements and then makes the writer the single, dirty holder. A request that finds the block owned, dirty, by another node first asks that owner for its modified copy and waits for the owner to report completion. A read then leaves both nodes as clean sharers. A write moves ownership to the requester.

The sequencer has six named states. IDLE accepts a request. DECIDE inspects the entry. FETCH waits for the owner write-back. INVAL issues invalidates. COLLECT waits for acknowledgements. GRANT sends the answer. The transitions are: IDLE→DECIDE on an accepted request; DECIDE→FETCH when another node owns the block; DECIDE→INVAL when a write finds other sharers; DECIDE→GRANT otherwise; FETCH→GRANT on owner completion; INVAL→COLLECT after the last invalidate; COLLECT→GRANT when all acknowledgements are in; GRANT→IDLE always.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry has an empty sharer vector and is clean; `req_ready` is high and `inv_valid`, `fetch_valid` and `grant_valid` are low. A first request to a block therefore sends no invalidate and no fetch.
- R2: A read to a clean block adds the requester to the sharer vector and is granted with no invalidate and no fetch, with `grant_excl` = 0.
- R3: A write to a clean block sends exactly one invalidate to each sharer except the requester. These go one per cycle in ascending node index order, each carrying the requested block on `inv_blk`.
- R4: A write that sent invalidates is granted only after as many `ack_valid` pulses as invalidates have been received.
- R5: After a write is granted, the requester is the only sharer and the block is dirty.
- R6: A request to a block that is dirty at another node first raises `fetch_valid` with `fetch_node` = the owner and `fetch_excl` = the request's write flag. This is held until `fetch_done`, before any grant, and sends no invalidate.
- R7: A read to a block dirty at another node leaves the block clean, with both the former owner and the requester as sharers.
- R8: A request from the node that already owns the dirty block is granted without fetch or invalidate, and the entry is unchanged.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after its grant, so later requests, to the same block or any other, are held.
- R10: Each grant is a single-cycle `grant_valid` pulse whose node, block and `grant_excl` (= write flag) match the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLKS) | Requested block |
| req_write | input | 1 | 1 = write, 0 = read |
| inv_valid | output | 1 | Invalidate message this cycle |
| inv_node | output | $clog2(NODES) | Node being invalidated |
| inv_blk | output | $clog2(BLKS) | Block being invalidated |
| ack_valid | input | 1 | One invalidate acknowledgement |
| fetch_valid | output | 1 | Owner fetch requested (held) |
| fetch_node | output | $clog2(NODES) | Owner node to fetch from |
| fetch_blk | output | $clog2(BLKS) | Block to fetch |
| fetch_excl | output | 1 | Owner must also drop its copy |
| fetch_done | input | 1 | Owner write-back complete |
| grant_valid | output | 1 | Grant pulse |
| grant_node | output | $clog2(NODES) | Node granted |
| grant_blk | output | $clog2(BLKS) | Block granted |
| grant_excl | output | 1 | Grant is for writing |

## Verification
The assertions assume the environment behaves like the nodes of a coherent system. An acknowledgement arrives only for an invalidate already sent, and `fetch_done` comes only while a fetch is pending. The bench's node model enforces both. It returns each acknowledgement at least one cycle after its invalidate and pulses `fetch_done` once, in the cycle after it sees `fetch_valid`. It never offers a request outside the handshake, and it runs directed scenarios followed by a long arithmetic mix of nodes, blocks and operations. A reference copy of the directory, kept in the bench, predicts each invalidate set, each fetch and each grant.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FETCH,
        ST_INVAL,
        ST_COLLECT,
        ST_GRANT
    } dir_state_e;
endpackage

// File: rtl/dir_pick.sv
// Lowest-set-bit picker: index and one-hot of the lowest asserted bit.
module dir_pick #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  hot,
    output logic          any
);
    always_comb begin
        idx = '0;
        hot = '0;
        any = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                hot = '0;
                hot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_store.sv
// Directory entries: sharer vector and dirty flag per block.
module dir_store #(
    parameter int NODES = 4,
    parameter int BLKS  = 4,
    localparam int BW = (BLKS > 1) ? $clog2(BLKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output logic [NODES-1:0] rd_pres,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  logic [NODES-1:0] wr_pres,
    input  logic             wr_dirty
);
    logic [NODES-1:0] pres_q  [BLKS];
    logic             dirty_q [BLKS];

    for (genvar g = 0; g < BLKS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[g]  <= '0;
                dirty_q[g] <= 1'b0;
            end else if (wr_en && (wr_blk == BW'(g))) begin
                pres_q[g]  <= wr_pres;
                dirty_q[g] <= wr_dirty;
            end
        end
    end

    assign rd_pres  = pres_q[rd_blk];
    assign rd_dirty = dirty_q[rd_blk];
endmodule

// File: rtl/dir_fsm.sv
// Per-request sequencer.
module dir_fsm
    import dir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int BLKS  = 4,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int BW = (BLKS > 1) ? $clog2(BLKS) : 1,
    localparam int CW = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NW-1:0]    req_node,
    input  logic [BW-1:0]    req_blk,
    input  logic             req_write,
    input  logic [NODES-1:0] ent_pres,
    input  logic             ent_dirty,
    input  logic [NW-1:0]    owner_idx,
    output logic [NODES-1:0] pend_mask,
    input  logic [NW-1:0]    tgt_idx,
    input  logic [NODES-1:0] tgt_hot,
    input  logic             ack_valid,
    input  logic             fetch_done,
    output logic             inv_valid,
    output logic [NW-1:0]    inv_node,
    output logic             fetch_valid,
    output logic [NW-1:0]    fetch_node,
    output logic             fetch_excl,
    output logic             grant_valid,
    output logic             grant_excl,
    output logic [NW-1:0]    cur_node,
    output logic [BW-1:0]    cur_blk,
    output logic             upd_en,
    output logic [NODES-1:0] upd_pres,
    output logic             upd_dirty
);
    dir_state_e       state_q, state_d;
    logic [NW-1:0]    node_q;
    logic [BW-1:0]    blk_q;
    logic             wr_q;
    logic [NODES-1:0] rem_q, rem_d;
    logic [CW-1:0]    sent_q, sent_d;
    logic [CW-1:0]    acks_q, acks_d;
    logic [NODES-1:0] self_bit;
    logic [NODES-1:0] others;
    logic             own_hit;

    assign self_bit = {{(NODES-1){1'b0}}, 1'b1} << node_q;
    assign others   = ent_pres & ~self_bit;
    assign own_hit  = ent_dirty && (ent_pres == self_bit);

    // State and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            node_q  <= '0;
            blk_q   <= '0;
            wr_q    <= 1'b0;
            rem_q   <= '0;
            sent_q  <= '0;
            acks_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            sent_q  <= sent_d;
            acks_q  <= acks_d;
            if (state_q == ST_IDLE && req_valid) begin
                node_q <= req_node;
                blk_q  <= req_blk;
                wr_q   <= req_write;
            end
        end
    end

    // Next state, message outputs and directory updates
    always_comb begin
        state_d     = state_q;
        rem_d       = rem_q;
        sent_d      = sent_q;
        acks_d      = acks_q;
        req_ready   = 1'b0;
        inv_valid   = 1'b0;
        fetch_valid = 1'b0;
        grant_valid = 1'b0;
        upd_en      = 1'b0;
        upd_pres    = ent_pres;
        upd_dirty   = ent_dirty;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                rem_d  = '0;
                sent_d = '0;
                acks_d = '0;
                if (own_hit) begin
                    state_d = ST_GRANT;
                end else if (ent_dirty) begin
                    state_d = ST_FETCH;
                end else if (wr_q && (others != '0)) begin
                    rem_d   = others;
                    state_d = ST_INVAL;
                end else begin
                    upd_en    = 1'b1;
                    upd_pres  = wr_q ? self_bit : (ent_pres | self_bit);
                    upd_dirty = wr_q;
                    state_d   = ST_GRANT;
                end
            end
            ST_FETCH: begin
                fetch_valid = 1'b1;
                if (fetch_done) begin
                    upd_en    = 1'b1;
                    upd_pres  = wr_q ? self_bit : (ent_pres | self_bit);
                    upd_dirty = wr_q;
                    state_d   = ST_GRANT;
                end
            end
            ST_INVAL: begin
                inv_valid = 1'b1;
                rem_d     = rem_q & ~tgt_hot;
                sent_d    = sent_q + CW'(1);
                acks_d    = acks_q + CW'(ack_valid);
                if ((rem_q & ~tgt_hot) == '0) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                acks_d = acks_q + CW'(ack_valid);
                if ((acks_q + CW'(ack_valid)) == sent_q) begin
                    upd_en    = 1'b1;
                    upd_pres  = self_bit;
                    upd_dirty = 1'b1;
                    state_d   = ST_GRANT;
                end
            end
            ST_GRANT: begin
                grant_valid = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend_mask  = rem_q;
    assign inv_node   = tgt_idx;
    assign fetch_node = owner_idx;
    assign fetch_excl = wr_q;
    assign grant_excl = wr_q;
    assign cur_node   = node_q;
    assign cur_blk    = blk_q;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
    parameter int NODES = 4,
    parameter int BLKS  = 4,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int BW = (BLKS > 1) ? $clog2(BLKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    input  logic          req_write,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    output logic [BW-1:0] inv_blk,
    input  logic          ack_valid,
    output logic          fetch_valid,
    output logic [NW-1:0] fetch_node,
    output logic [BW-1:0] fetch_blk,
    output logic          fetch_excl,
    input  logic          fetch_done,
    output logic          grant_valid,
    output logic [NW-1:0] grant_node,
    output logic [BW-1:0] grant_blk,
    output logic          grant_excl
);
    logic [NODES-1:0] ent_pres;
    logic             ent_dirty;
    logic [NW-1:0]    owner_idx;
    logic [NODES-1:0] owner_hot;
    logic             owner_any;
    logic [NODES-1:0] pend_mask;
    logic [NW-1:0]    tgt_idx;
    logic [NODES-1:0] tgt_hot;
    logic             tgt_any;
    logic [NW-1:0]    cur_node;
    logic [BW-1:0]    cur_blk;
    logic             upd_en;
    logic [NODES-1:0] upd_pres;
    logic             upd_dirty;

    dir_store #(.NODES(NODES), .BLKS(BLKS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_blk   (cur_blk),
        .rd_pres  (ent_pres),
        .rd_dirty (ent_dirty),
        .wr_en    (upd_en),
        .wr_blk   (cur_blk),
        .wr_pres  (upd_pres),
        .wr_dirty (upd_dirty)
    );

    dir_pick #(.W(NODES)) u_owner (
        .vec (ent_pres),
        .idx (owner_idx),
        .hot (owner_hot),
        .any (owner_any)
    );

    dir_pick #(.W(NODES)) u_target (
        .vec (pend_mask),
        .idx (tgt_idx),
        .hot (tgt_hot),
        .any (tgt_any)
    );

    dir_fsm #(.NODES(NODES), .BLKS(BLKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_node    (req_node),
        .req_blk     (req_blk),
        .req_write   (req_write),
        .ent_pres    (ent_pres),
        .ent_dirty   (ent_dirty),
        .owner_idx   (owner_idx),
        .pend_mask   (pend_mask),
        .tgt_idx     (tgt_idx),
        .tgt_hot     (tgt_hot),
        .ack_valid   (ack_valid),
        .fetch_done  (fetch_done),
        .inv_valid   (inv_valid),
        .inv_node    (inv_node),
        .fetch_valid (fetch_valid),
        .fetch_node  (fetch_node),
        .fetch_excl  (fetch_excl),
        .grant_valid (grant_valid),
        .grant_excl  (grant_excl),
        .cur_node    (cur_node),
        .cur_blk     (cur_blk),
        .upd_en      (upd_en),
        .upd_pres    (upd_pres),
        .upd_dirty   (upd_dirty)
    );

    assign inv_blk    = cur_blk;
    assign fetch_blk  = cur_blk;
    assign grant_node = cur_node;
    assign grant_blk  = cur_blk;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
    parameter int NW = 2,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          inv_valid,
    input logic [NW-1:0] inv_node,
    input logic          fetch_valid,
    input logic [NW-1:0] fetch_node,
    input logic          fetch_done,
    input logic          grant_valid,
    input logic [NW-1:0] grant_node
);
    // R9: no message goes out while a request can still be accepted
    a_r9_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid || fetch_valid || grant_valid) |-> !req_ready);

    // R3: the requester never receives an invalidate for its own request
    a_r3_inv_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != grant_node));

    // R6: a fetch stays up with the same owner until the owner completes
    a_r6_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_done) |=> (fetch_valid && $stable(fetch_node)));

    // R6: owner fetch and invalidates never overlap
    a_r6_no_inv_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && fetch_valid));

    // R10: a grant lasts exactly one cycle and is followed by readiness
    a_r10_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (!grant_valid && req_ready));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NW(NW), .BW(BW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .inv_valid   (inv_valid),
    .inv_node    (inv_node),
    .fetch_valid (fetch_valid),
    .fetch_node  (fetch_node),
    .fetch_done  (fetch_done),
    .grant_valid (grant_valid),
    .grant_node  (grant_node)
);

// File: tb/dir_home_ctrl_bench.sv
`timescale 1ns/1ps
module dir_home_ctrl_bench;
    localparam int NODES = 4;
    localparam int BLKS  = 4;
    localparam int NW = 2;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_blk = '0;
    logic          req_write = 1'b0;
    logic          inv_valid;
    logic [NW-1:0] inv_node;
    logic [BW-1:0] inv_blk;
    logic          ack_valid = 1'b0;
    logic          fetch_valid;
    logic [NW-1:0] fetch_node;
    logic [BW-1:0] fetch_blk;
    logic          fetch_excl;
    logic          fetch_done = 1'b0;
    logic          grant_valid;
    logic [NW-1:0] grant_node;
    logic [BW-1:0] grant_blk;
    logic          grant_excl;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int model_pres  [BLKS];
    bit model_dirty [BLKS];

    always #2 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLKS(BLKS)) u_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_blk(req_blk), .req_write(req_write),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_blk(inv_blk),
        .ack_valid(ack_valid),
        .fetch_valid(fetch_valid), .fetch_node(fetch_node), .fetch_blk(fetch_blk),
        .fetch_excl(fetch_excl), .fetch_done(fetch_done),
        .grant_valid(grant_valid), .grant_node(grant_node), .grant_blk(grant_blk),
        .grant_excl(grant_excl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One request, with a node model answering invalidates and fetches
    task automatic do_req(input int n, input int b, input bit w);
        int  self_b, exp_inv, exp_fetch_node, pending, cyc, last_inv;
        int  inv_seen, fetch_cnt, f_node, f_excl;
        bit  exp_fetch, own, done, ready_bad, order_bad, blk_bad, early;
        self_b = 1 << n;
        own = model_dirty[b] && (model_pres[b] == self_b);
        exp_fetch = model_dirty[b] && !own;
        exp_fetch_node = 0;
        for (int i = NODES - 1; i >= 0; i--) if (model_pres[b][i]) exp_fetch_node = i;
        exp_inv = (!model_dirty[b] && w) ? (model_pres[b] & ~self_b) : 0;

        @(negedge clk);
        req_valid = 1'b1; req_node = NW'(n); req_blk = BW'(b); req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        done = 0; cyc = 0; pending = 0; last_inv = -1; inv_seen = 0;
        fetch_cnt = 0; f_node = -1; f_excl = -1;
        ready_bad = 0; order_bad = 0; blk_bad = 0; early = 0;
        while (!done && cyc < 200) begin
            if (req_ready) ready_bad = 1;
            if (inv_valid) begin
                if (int'(inv_node) <= last_inv) order_bad = 1;
                if (int'(inv_blk) != b) blk_bad = 1;
                last_inv = int'(inv_node);
                inv_seen = inv_seen | (1 << inv_node);
            end
            if (fetch_valid && !fetch_done) begin
                fetch_cnt++; f_node = int'(fetch_node); f_excl = int'(fetch_excl);
                if (int'(fetch_blk) != b) blk_bad = 1;
            end
            if (grant_valid) begin
                done = 1;
                if (pending != 0) early = 1;
                check(int'(grant_node) == n, "R10 grant node", grant_node, n);
                check(int'(grant_blk) == b, "R10 grant block", grant_blk, b);
                check(grant_excl == w, "R10 grant excl", grant_excl, w);
            end else begin
                ack_valid = (pending > 0);
                if (pending > 0) pending--;
                if (inv_valid) pending++;
                if (fetch_done) fetch_done = 1'b0;
                else if (fetch_valid) fetch_done = 1'b1;
                @(negedge clk);
                cyc++;
            end
        end
        ack_valid = 1'b0; fetch_done = 1'b0;
        check(done, "R10 grant seen", done, 1);
        check(!ready_bad, "R9 ready low while busy", ready_bad, 0);
        check(inv_seen == exp_inv, "R3 invalidate set", inv_seen, exp_inv);
        check(!order_bad && !blk_bad, "R3 invalidate order/block", order_bad, 0);
        check(!early, "R4 grant after all acks", early, 0);
        if (own)
            check(fetch_cnt == 0 && inv_seen == 0, "R8 owner hit quiet", fetch_cnt, 0);
        else if (exp_fetch) begin
            check(fetch_cnt >= 1 && f_node == exp_fetch_node, "R6 fetch owner", f_node, exp_fetch_node);
            check(f_excl == int'(w), "R6 fetch excl", f_excl, w);
        end else if (!w)
            check(fetch_cnt == 0 && inv_seen == 0, "R2 clean read quiet", fetch_cnt, 0);
        else
            check(fetch_cnt == 0, "R5 clean write no fetch", fetch_cnt, 0);

        // reference directory update
        if (own) begin
        end else if (w) begin
            model_pres[b] = self_b; model_dirty[b] = 1;
        end else begin
            model_pres[b] = model_pres[b] | self_b; model_dirty[b] = 0;
        end
    endtask

    initial begin
        for (int i = 0; i < BLKS; i++) begin model_pres[i] = 0; model_dirty[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(!inv_valid && !fetch_valid && !grant_valid, "R1 quiet after reset",
              {inv_valid, fetch_valid, grant_valid}, 0);
        // R1: first write to an empty block: no invalidate, no fetch
        do_req(0, 0, 1);
        // R6/R7: read by other node fetches from owner, both become sharers
        do_req(1, 0, 0);
        do_req(2, 0, 0);
        // R3/R4/R5: write invalidates 0,1,2
        do_req(3, 0, 1);
        // R8: owner re-read and re-write
        do_req(3, 0, 0);
        do_req(3, 0, 1);
        // R6: write to dirty block, ownership moves
        do_req(1, 0, 1);
        // R7 follow-up: read then write shows former owner still present
        do_req(2, 0, 0);
        do_req(0, 0, 1);
        // R2: reads on other blocks
        for (int n = 0; n < NODES; n++) do_req(n, 1, 0);
        do_req(2, 1, 1);
        // Arithmetic mix over all nodes, blocks and operations
        for (int k = 0; k < 600; k++) begin
            int v;
            v = (k * 37 + (k / 7) * 11 + 5) % 64;
            do_req(v % NODES, (v / NODES) % BLKS, ((v / 16) % 3) == 0);
        end
        finish_run();
    end

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        finish_run();
    end
endmodule